// File: doc/BRIEF.md
# Always-on timer and pulse counter

This block is a small low-power counter with a four-register write/read interface. In timer mode it counts ticks from one of three selectable clock-enable strobes, optionally divided by a power-of-two prescaler. In pulse mode it counts the active edges of one of four asynchronous inputs: three external pins and one internal trigger line. Each of these inputs passes through a two-flop synchronizer and an optional stability filter before edge detection.

The counter is compared against a programmable limit. When the count equals the limit and an increment arrives, the count wraps to zero and a sticky completion flag is set. Software clears the flag by writing a one to it. The interrupt output follows the flag when interrupts are enabled.

A debug-halt input can freeze counting, unless the timer is configured to keep running during debug. Clearing the enable bit returns the counter, the prescaler and the filter to zero. The count register accepts software writes only while the timer is disabled.

Top module: `aot_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register 0 (control) has these fields:
  - bit 0: enable.
  - bit 1: mode (0 = timer, 1 = pulse).
  - bit 2: polarity.
  - bits 4:3: pulse source.
  - bit 5: interrupt enable.
  - bit 6: run during debug.
  - bit 7: completion flag.

  In timer mode with bypass (register 1 bit 4) set, the count rises by one for each tick of the strobe picked by register 1 bits 6:5. Code 0 picks `osc_tick`, code 2 picks `rtc_tick` and code 3 picks `per_tick`. Code 1 picks nothing, and the count stays put.
- R3: In timer mode with bypass clear, a prescale value n in register 1 bits 3:0 gives one count per 2^(n+1) selected ticks, for any n from 0 to 15.
- R4: In pulse mode, source code 0, 1 or 2 selects `pulse_pin[0]`, `[1]` or `[2]`, and code 3 selects `trig_in`. Activity on the inputs that are not selected leaves the count unchanged.
- R5: With polarity 0 the count rises on each rising edge of the selected input. With polarity 1 it rises on each falling edge. Edges of the other direction are not counted.
- R6: In pulse mode with bypass clear, a new input level is taken only after it has held for 2^(n+1) clock cycles after the synchronizer. A shorter excursion is not counted. With bypass set, a pin change shows in the count on the third rising clock edge after it.
- R7: Register 2 holds the compare value. When the count equals it and an increment occurs, the count goes to zero and the flag (control bit 7) sets on that same increment.
- R8: Writing 1 to control bit 7 clears the flag. Writing 0 there leaves the flag unchanged.
- R9: `irq` is high exactly when the flag is set and control bit 5 is set.
- R10: With control bit 6 clear, counting freezes while `dbg_halt` is high. With bit 6 set, counting continues during the halt.
- R11: Writing control bit 0 from 1 to 0 zeroes the count. Writes to register 3 (count) take effect only while the timer is disabled, and are ignored while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 32 | Read data (combinational) |
| osc_tick | input | 1 | Tick strobe of the internal oscillator domain |
| rtc_tick | input | 1 | Tick strobe of the real-time clock domain |
| per_tick | input | 1 | Tick strobe of the peripheral clock domain |
| pulse_pin | input | 3 | Asynchronous external pulse inputs |
| trig_in | input | 1 | Asynchronous internal trigger pulse input |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |

## Verification
- **Writes and timer ticks:** a register write or a timer-mode tick present at a rising edge is visible on `rd_data` right after that edge. The bench drives each stimulus at a falling edge and reads at a later falling edge.
- **Pulse inputs with bypass:** a pulse-input change needs three edges. These are two synchronizer flops and the counter itself. The latency check samples after two edges, expecting no change, and after three, expecting the increment.
- **Pulse inputs with the filter:** with the filter active, an excursion is accepted in its 2^(n+1)-th cycle after the synchronizer. The bench therefore holds pulses for exactly 2^(n+1)-1 and 2^(n+1) cycles, and waits at least twice the filter length before reading.

// File: rtl/aot_pkg.sv
// Shared definitions for the always-on timer: register indices, field
// positions and the packed control register layout.
package aot_pkg;

    localparam int DIV_SEL_W  = 4;   // prescale field width
    localparam int CTRL_BITS  = 7;   // stored control bits below the flag

    // control register field positions
    localparam int CT_EN   = 0;
    localparam int CT_FLAG = 7;

    // prescale register field positions
    localparam int PS_DIV_LO  = 0;
    localparam int PS_BYP     = 4;
    localparam int PS_CSEL_LO = 5;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_PRESC = 2'd1,
        REG_CMP   = 2'd2,
        REG_CNT   = 2'd3
    } aot_reg_e;

    typedef enum logic [1:0] {
        CK_OSC = 2'd0,
        CK_RSV = 2'd1,
        CK_RTC = 2'd2,
        CK_PER = 2'd3
    } aot_clk_e;

    // packed so that bit positions match the control register bits 6:0
    typedef struct packed {
        logic       dbg_run;
        logic       irq_en;
        logic [1:0] src;
        logic       pol;
        logic       pulse;
        logic       en;
    } aot_ctrl_t;

endpackage

// File: rtl/aot_sync.sv
// Two-flop synchronizer bank.
// Assumes each bit is an independent asynchronous level; no bus coherence.
module aot_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // capture and settle one asynchronous level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end

            assign sync_out[i] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/aot_divfilt.sv
// Shared prescale / filter engine.
// In timer mode the accumulator divides the selected tick by 2^(n+1).
// In pulse mode it measures how long the synchronized input has differed
// from the accepted level and accepts the new level after 2^(n+1) cycles.
// Bypass skips whichever function is active.
// Assumes lvl_in is already synchronous to clk.
module aot_divfilt #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             pulse_mode,
    input  logic             bypass,
    input  logic             pol,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             tick,
    input  logic             lvl_in,
    output logic             inc
);

    localparam int ACC_W = 1 << SEL_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] limit;
    logic [ACC_W:0]   ratio;
    logic             lvl_q;
    logic             differ;
    logic             at_lim;
    logic             accept;

    // limit is ratio-1, ratio = 2^(n+1)
    always_comb begin
        ratio  = (ACC_W+1)'(2) << div_sel;
        limit  = ACC_W'(ratio - 1'b1);
        at_lim = acc_q >= limit;
        differ = lvl_in != lvl_q;
        accept = run && differ && (bypass || at_lim);
    end

    // increment request for the counter
    always_comb begin
        if (!pulse_mode) inc = run && tick && (bypass || at_lim);
        else             inc = accept && (lvl_in == ~pol);
    end

    // accumulator and accepted-level state
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            lvl_q <= 1'b0;
        end else if (run) begin
            if (!pulse_mode) begin
                if (tick && !bypass) acc_q <= at_lim ? '0 : acc_q + 1'b1;
            end else if (!differ) begin
                acc_q <= '0;
            end else if (accept) begin
                acc_q <= '0;
                lvl_q <= lvl_in;
            end else begin
                acc_q <= acc_q + 1'b1;
            end
        end
    end

    // R3
    prescale_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pulse_mode && !bypass && inc) |=> !(inc && !bypass && !pulse_mode));

    // R6
    level_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && inc && !clear) |=> (lvl_q == $past(lvl_in)) && (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/aot_counter.sv
// Main count register with compare, wrap and sticky completion flag.
// Assumes inc is already gated by enable and debug-halt.
module aot_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             en,
    input  logic             zero,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    logic match;

    assign match = cnt == cmp;

    // count update: disable zeroing, software load, then increment with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (zero) begin
            cnt <= '0;
        end else if (!en && wr_cnt) begin
            cnt <= wr_val;
        end else if (inc) begin
            cnt <= match ? '0 : cnt + 1'b1;
        end
    end

    // sticky flag: set on matching increment, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (inc && match) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // R7
    flag_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == $past(cmp)) && (cnt == '0));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(zero) && (cnt != $past(cnt))) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

endmodule

// File: rtl/aot_timer.sv
// Always-on timer / pulse counter top: register file, clock-strobe select,
// pulse-source select and the glue between synchronizer, divider/filter
// and counter. Assumes tick strobes are one-cycle enables synchronous to clk.
module aot_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              osc_tick,
    input  logic              rtc_tick,
    input  logic              per_tick,
    input  logic [2:0]        pulse_pin,
    input  logic              trig_in,
    input  logic              dbg_halt,
    output logic              irq
);
    import aot_pkg::*;

    localparam int NSRC = 4;

    aot_ctrl_t            ctrl_q;
    logic [DIV_SEL_W-1:0] div_q;
    logic                 byp_q;
    aot_clk_e             csel_q;
    logic [CNT_W-1:0]     cmp_q;
    logic [CNT_W-1:0]     cnt;
    logic                 flag;
    logic                 wr_ctrl, wr_presc, wr_cmp, wr_cnt;
    logic                 zero, flag_clr, run, tick, inc, lvl_sel;
    logic [NSRC-1:0]      sync_q;

    // write decode
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
        wr_presc = wr_en && (wr_addr == REG_PRESC);
        wr_cmp   = wr_en && (wr_addr == REG_CMP);
        wr_cnt   = wr_en && (wr_addr == REG_CNT);
        zero     = wr_ctrl && ctrl_q.en && !wr_data[CT_EN];
        flag_clr = wr_ctrl && wr_data[CT_FLAG];
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= aot_ctrl_t'(wr_data[CTRL_BITS-1:0]);
    end

    // prescale / clock-select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            byp_q  <= 1'b0;
            csel_q <= CK_OSC;
        end else if (wr_presc) begin
            div_q  <= wr_data[PS_DIV_LO +: DIV_SEL_W];
            byp_q  <= wr_data[PS_BYP];
            csel_q <= aot_clk_e'(wr_data[PS_CSEL_LO +: 2]);
        end
    end

    // compare register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wr_data[CNT_W-1:0];
    end

    // timer tick source select; reserved code gives no ticks
    always_comb begin
        case (csel_q)
            CK_OSC:  tick = osc_tick;
            CK_RTC:  tick = rtc_tick;
            CK_PER:  tick = per_tick;
            default: tick = 1'b0;
        endcase
    end

    // run qualifier: enabled and not frozen by debug halt
    assign run     = ctrl_q.en && (!dbg_halt || ctrl_q.dbg_run);
    assign lvl_sel = sync_q[ctrl_q.src];
    assign irq     = flag && ctrl_q.irq_en;

    aot_sync #(.W(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({trig_in, pulse_pin}),
        .sync_out (sync_q)
    );

    aot_divfilt #(.SEL_W(DIV_SEL_W)) u_divfilt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!ctrl_q.en),
        .run        (run),
        .pulse_mode (ctrl_q.pulse),
        .bypass     (byp_q),
        .pol        (ctrl_q.pol),
        .div_sel    (div_q),
        .tick       (tick),
        .lvl_in     (lvl_sel),
        .inc        (inc)
    );

    aot_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .en       (ctrl_q.en),
        .zero     (zero),
        .wr_cnt   (wr_cnt),
        .wr_val   (wr_data[CNT_W-1:0]),
        .cmp      (cmp_q),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .flag     (flag)
    );

    // register read mux
    always_comb begin
        case (aot_reg_e'(rd_addr))
            REG_CTRL:  rd_data = DATA_W'({flag, ctrl_q});
            REG_PRESC: rd_data = DATA_W'({csel_q, byp_q, div_q});
            REG_CMP:   rd_data = DATA_W'(cmp_q);
            default:   rd_data = DATA_W'(cnt);
        endcase
    end

    // R10
    debug_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && dbg_halt && !ctrl_q.dbg_run && !wr_ctrl) |=> $stable(cnt));

    // R11
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !ctrl_q.en) |=> (cnt == $past(wr_data[CNT_W-1:0])));

    // R11
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && wr_ctrl && !wr_data[CT_EN]) |=> (cnt == '0));

endmodule

// File: tb/aot_timer_test.sv
module aot_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        osc_tick = 1'b0, rtc_tick = 1'b0, per_tick = 1'b0;
    logic [2:0]  pulse_pin = '0;
    logic        trig_in = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    aot_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .osc_tick(osc_tick), .rtc_tick(rtc_tick), .per_tick(per_tick),
        .pulse_pin(pulse_pin), .trig_in(trig_in), .dbg_halt(dbg_halt),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle strobes on a tick line: 0 osc, 1 rtc, 2 per
    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which == 0) osc_tick = 1'b1;
            else if (which == 1) rtc_tick = 1'b1;
            else per_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0; rtc_tick = 1'b0; per_tick = 1'b0;
        end
    endtask

    task automatic set_in(input int idx, input logic v);
        if (idx < 3) pulse_pin[idx] = v;
        else trig_in = v;
    endtask

    // ctrl word builder: en, mode, pol, src, ie, dbg
    function automatic logic [31:0] cw(input bit en, input bit pm, input bit pol,
                                       input int src, input bit ie, input bit dbg);
        return {24'b0, 1'b0, dbg, ie, src[1:0], pol, pm, en};
    endfunction

    logic [31:0] v;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        wr(2, 32'd1000);

        // R2 clock select sweep with bypass: osc 1, rtc 2, per 4 ticks
        for (int s = 0; s < 4; s++) begin
            int exp_c;
            wr(0, 32'h0);
            wr(1, (32'(s) << 5) | 32'h10);
            wr(0, cw(1, 0, 0, 0, 0, 0));
            ticks(0, 1); ticks(1, 2); ticks(2, 4);
            exp_c = (s == 0) ? 1 : (s == 2) ? 2 : (s == 3) ? 4 : 0;
            rd(3, v);
            check("R2 clock select count", v, 32'(exp_c));
        end

        // R3 prescaler ratio 2^(n+1), continuous ticks
        for (int n = 0; n < 4; n++) begin
            int r;
            r = 2 << n;
            wr(0, 32'h0);
            wr(1, 32'(n));
            wr(0, cw(1, 0, 0, 0, 0, 0));
            osc_tick = 1'b1;
            idle(3 * r + 1);
            osc_tick = 1'b0;
            rd(3, v);
            check("R3 prescaled count", v, 32'd3);
        end
        // R3 top prescale value 15: 65535 ticks none, one more gives one
        wr(0, 32'h0);
        wr(1, 32'd15);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        osc_tick = 1'b1;
        idle(65535);
        rd(3, v);
        check("R3 n=15 before boundary", v, 32'd0);
        idle(1);
        osc_tick = 1'b0;
        rd(3, v);
        check("R3 n=15 at boundary", v, 32'd1);

        // R4 R5 pulse source and polarity sweep with bypass
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                int other;
                other = (s + 1) % 4;
                wr(0, 32'h0);
                for (int k = 0; k < 4; k++) set_in(k, p[0]);
                wr(1, 32'h10);
                idle(4);
                wr(0, cw(1, 1, p[0], s, 0, 0));
                idle(6);
                for (int e = 0; e < 3; e++) begin
                    set_in(s, ~p[0]); idle(4);
                    set_in(s, p[0]);  idle(4);
                end
                for (int e = 0; e < 2; e++) begin
                    set_in(other, ~p[0]); idle(4);
                    set_in(other, p[0]);  idle(4);
                end
                rd(3, v);
                check(p ? "R5 falling edges counted" : "R4 selected source rising edges", v, 32'd3);
            end
        end
        for (int k = 0; k < 4; k++) set_in(k, 1'b0);

        // R6 latency with bypass: third edge after pin change
        wr(0, 32'h0);
        wr(1, 32'h10);
        idle(4);
        wr(0, cw(1, 1, 0, 0, 0, 0));
        idle(4);
        pulse_pin[0] = 1'b1;
        idle(2);
        rd(3, v);
        check("R6 no count after two edges", v, 32'd0);
        idle(1);
        rd(3, v);
        check("R6 count on third edge", v, 32'd1);
        pulse_pin[0] = 1'b0;
        idle(4);

        // R6 filter: excursion of 2^(n+1)-1 cycles rejected, 2^(n+1) accepted
        for (int n = 0; n < 3; n++) begin
            int r;
            r = 2 << n;
            wr(0, 32'h0);
            wr(1, 32'(n));
            wr(0, cw(1, 1, 0, 0, 0, 0));
            idle(6);
            pulse_pin[0] = 1'b1; idle(r - 1);
            pulse_pin[0] = 1'b0; idle(2 * r + 6);
            rd(3, v);
            check("R6 short glitch rejected", v, 32'd0);
            pulse_pin[0] = 1'b1; idle(r);
            pulse_pin[0] = 1'b0; idle(2 * r + 6);
            rd(3, v);
            check("R6 stable pulse accepted", v, 32'd1);
        end

        // R7 R8 R9 compare, wrap, flag and irq
        wr(0, 32'h0);
        wr(0, 32'h80);
        wr(1, 32'h10);
        wr(2, 32'd3);
        wr(0, cw(1, 0, 0, 0, 1, 0));
        ticks(0, 3);
        rd(3, v);
        check("R7 count at compare", v, 32'd3);
        rd(0, v);
        check("R7 flag still clear", {31'b0, v[7]}, 32'd0);
        check("R9 irq low before match", {31'b0, irq}, 32'd0);
        ticks(0, 1);
        rd(3, v);
        check("R7 wrap to zero", v, 32'd0);
        rd(0, v);
        check("R7 flag set", {31'b0, v[7]}, 32'd1);
        check("R9 irq follows flag", {31'b0, irq}, 32'd1);
        ticks(0, 1);
        rd(3, v);
        check("R7 counting resumes", v, 32'd1);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        rd(0, v);
        check("R8 write zero keeps flag", {31'b0, v[7]}, 32'd1);
        check("R9 irq masked", {31'b0, irq}, 32'd0);
        wr(0, cw(1, 0, 0, 0, 1, 0));
        check("R9 irq unmasked", {31'b0, irq}, 32'd1);
        wr(0, cw(1, 0, 0, 0, 1, 0) | 32'h80);
        rd(0, v);
        check("R8 write one clears flag", {31'b0, v[7]}, 32'd0);
        check("R9 irq drops with flag", {31'b0, irq}, 32'd0);

        // R10 debug halt
        wr(2, 32'd1000);
        wr(0, 32'h0);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        dbg_halt = 1'b1;
        ticks(0, 5);
        rd(3, v);
        check("R10 frozen during halt", v, 32'd0);
        dbg_halt = 1'b0;
        ticks(0, 2);
        rd(3, v);
        check("R10 runs after halt", v, 32'd2);
        wr(0, cw(1, 0, 0, 0, 0, 1));
        dbg_halt = 1'b1;
        ticks(0, 3);
        dbg_halt = 1'b0;
        rd(3, v);
        check("R10 runs in debug when allowed", v, 32'd5);

        // R11 disable zeroes, writes only while disabled
        wr(0, 32'h0);
        rd(3, v);
        check("R11 disable zeroes count", v, 32'd0);
        wr(3, 32'd9);
        rd(3, v);
        check("R11 write while disabled", v, 32'd9);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        wr(3, 32'd20);
        rd(3, v);
        check("R11 write ignored while enabled", v, 32'd9);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule